// File: doc/BRIEF.md
# Coincident-current core store cycle sequencer

This block sequences every access to a word-organised magnetic core plane that is selected by coincident current. When the host makes a request, the block latches an address, a cycle kind, a data word, a modify mask and two drive widths. It then runs a read half-cycle and a write half-cycle. In the read half it drives the X and Y select lines and the read drive, and it strobes the sense outputs in the last clock of that drive. In the write half it sets up the per-bit inhibit lines one clock ahead of the write drive.

A read clears every addressed core to 0. A core that held a 1 flips during the read and gives a large sense pulse, so a sensed 1 means a stored 1. Because of this, the block never returns to idle without writing a word back. It supports three cycle kinds. Restore writes back the sensed word. Clear-write stores the host word. Modify merges host bits into the sensed word under a mask.

An optional stall lets the host compute the modified word itself. After the read data is returned, the sequencer waits with all drives off until the host marks the new data valid.

Top module: `coinc_core_seq`

## Requirements
- R1: The X select is one-hot on line `req_addr[11:6]` and the Y select is one-hot on line `req_addr[5:0]`. Both are asserted together in every cycle in which `rd_drv` or `wr_drv` is high. Both are all zero in every other cycle.
- R2: A request (`req` high at a clock edge) is taken only while `busy` is low. `ack` is then high for exactly the first read-drive cycle. A `req` seen while `busy` is high gives no `ack` and changes no timing.
- R3: `rd_drv` is high for `rd_width` consecutive cycles, starting in the cycle after acceptance. A width of 0 counts as 1. `sense_strb` is high only in the last of those cycles. A `sense` bit of 1 sampled there is returned as a stored 1.
- R4: `done` is high for one cycle, in the cycle right after the read drive ends. In that same cycle `rdata` shows the sensed word, and `rdata` keeps that value until the next `done`.
- R5: `busy` is high from the first read-drive cycle until the end of the final gap. Every read half-cycle is followed by a write half-cycle before `busy` falls.
- R6: `inhibit` is nonzero only in the set-up cycle just before `wr_drv` and during `wr_drv`. In those cycles, bit i is high exactly when bit i of the target word is 0. `wr_drv` is high for `wr_width` cycles, and a width of 0 counts as 1. `inhibit` is all zero while `rd_drv` is high.
- R7: Kind 0 (restore) targets the sensed word. Kind 3 behaves as kind 0.
- R8: Kind 1 (clear-write) targets `req_wdata`, and `rdata` still returns the old word.
- R9: Kind 2 (modify) without the stall targets `(sensed & ~req_mask) | (req_wdata & req_mask)`.
- R10: With `hold_en` high at acceptance and kind 2, the block waits after the read gap with every drive and inhibit off. When `wdata_vld` is seen, it targets the `req_wdata` presented in that cycle, and the set-up cycle follows. `wdata_vld` has no effect at any other time.
- R11: Exactly GAP_CYC (2 by default) cycles with no drive follow the read drive and also follow the write drive.
- R12: After reset, every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe |
| req_kind | input | 2 | Cycle kind: 0 restore, 1 clear-write, 2 modify, 3 as 0 |
| req_addr | input | 12 | Word address; high half selects X, low half selects Y |
| req_wdata | input | 16 | Host word (also the stalled modify data) |
| req_mask | input | 16 | Modify mask; 1 takes the host bit |
| rd_width | input | 8 | Read drive length in cycles |
| wr_width | input | 8 | Write drive length in cycles |
| hold_en | input | 1 | Stall modify cycles for host data |
| wdata_vld | input | 1 | Host data valid during the stall |
| ack | output | 1 | Request taken |
| busy | output | 1 | Access in progress |
| done | output | 1 | Read data valid pulse |
| rdata | output | 16 | Sensed word |
| sense | input | 16 | Sense amplifier outputs, 1 = large pulse |
| sense_strb | output | 1 | Sense sample strobe |
| rd_drv | output | 1 | Read drive enable |
| wr_drv | output | 1 | Write drive enable |
| x_sel | output | 64 | One-hot X line selects |
| y_sel | output | 64 | One-hot Y line selects |
| inhibit | output | 16 | Per-bit inhibit enables |

## Verification
A wrong state in the sequencer shows up in the same cycle as a drive, strobe or inhibit pattern that does not match the cycle-by-cycle expectation. It can also show up as a lone X or Y select. The checks compare those pins on every clock of every access.

A wrong target word shows up later, in the behavioural plane. The next read of that address returns wrong data, and the plane content checked right after `busy` falls also differs. A sequencer that skipped the restore would drop `busy` with a read still pending, and the plane would hold zeros.

// File: rtl/coinc_core_pkg.sv
package coinc_core_pkg;
   typedef enum logic [1:0] {
      CYC_RESTORE = 2'd0,
      CYC_CLEARWR = 2'd1,
      CYC_MODIFY  = 2'd2,
      CYC_RSVD    = 2'd3
   } cyc_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_GAP_R,
      ST_HOLD,
      ST_SETUP,
      ST_WRITE,
      ST_GAP_W
   } seq_st_e;
endpackage

// File: rtl/coinc_line_decode.sv
module coinc_line_decode #(
   parameter int IDX_W = 6,
   localparam int LINES = 1 << IDX_W
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             en,
   output logic [LINES-1:0] lines
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign lines[i] = en && (idx == IDX_W'(i));
   end
endmodule

// File: rtl/coinc_phase_timer.sv
module coinc_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign last = (cnt == '0);
endmodule

// File: rtl/coinc_core_seq.sv
module coinc_core_seq
   import coinc_core_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 16,
   parameter int CNT_W        = 8,
   parameter int GAP_CYC      = 2,
   parameter bit HOLD_SUPPORT = 1'b1,
   localparam int Y_W     = ADDR_W / 2,
   localparam int X_W     = ADDR_W - Y_W,
   localparam int X_LINES = 1 << X_W,
   localparam int Y_LINES = 1 << Y_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [1:0]         req_kind,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [DATA_W-1:0]  req_mask,
   input  logic [CNT_W-1:0]   rd_width,
   input  logic [CNT_W-1:0]   wr_width,
   input  logic               hold_en,
   input  logic               wdata_vld,
   output logic               ack,
   output logic               busy,
   output logic               done,
   output logic [DATA_W-1:0]  rdata,
   input  logic [DATA_W-1:0]  sense,
   output logic               sense_strb,
   output logic               rd_drv,
   output logic               wr_drv,
   output logic [X_LINES-1:0] x_sel,
   output logic [Y_LINES-1:0] y_sel,
   output logic [DATA_W-1:0]  inhibit
);
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (GAP_CYC < 1 || GAP_CYC >= (1 << CNT_W)) begin : g_bad_gap
      $error("GAP_CYC must fit the timer and be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC);

   seq_st_e            st;
   cyc_kind_e          kind_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q, mask_q, rdata_q, target;
   logic [CNT_W-1:0]   wr_w_q;
   logic               held_q, ack_q, done_q;
   logic               hold_act;
   logic               tmr_load, tmr_last;
   logic [CNT_W-1:0]   tmr_val;
   logic               drive_on;
   logic               accept;

   assign accept = (st == ST_IDLE) && req;

   if (HOLD_SUPPORT) begin : g_hold
      logic hold_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold_q <= 1'b0;
         else if (accept)
            hold_q <= hold_en;
      end
      assign hold_act = hold_q && (kind_q == CYC_MODIFY);
   end else begin : g_nohold
      assign hold_act = 1'b0;
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = GAP_LD;
      unique case (st)
         ST_IDLE:  begin tmr_load = req;      tmr_val = rd_width; end
         ST_READ:  tmr_load = tmr_last;
         ST_SETUP: begin tmr_load = 1'b1;     tmr_val = wr_w_q;   end
         ST_WRITE: tmr_load = tmr_last;
         default:  tmr_load = 1'b0;
      endcase
   end

   coinc_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         kind_q  <= CYC_RESTORE;
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
         rdata_q <= '0;
         wr_w_q  <= '0;
         held_q  <= 1'b0;
         ack_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         ack_q  <= 1'b0;
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: if (req) begin
               st      <= ST_READ;
               kind_q  <= cyc_kind_e'(req_kind);
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               mask_q  <= req_mask;
               wr_w_q  <= wr_width;
               held_q  <= 1'b0;
               ack_q   <= 1'b1;
            end
            ST_READ: if (tmr_last) begin
               st      <= ST_GAP_R;
               rdata_q <= sense;
               done_q  <= 1'b1;
            end
            ST_GAP_R: if (tmr_last)
               st <= hold_act ? ST_HOLD : ST_SETUP;
            ST_HOLD: if (wdata_vld) begin
               st      <= ST_SETUP;
               wdata_q <= req_wdata;
               held_q  <= 1'b1;
            end
            ST_SETUP: st <= ST_WRITE;
            ST_WRITE: if (tmr_last) st <= ST_GAP_W;
            ST_GAP_W: if (tmr_last) st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (kind_q)
         CYC_CLEARWR: target = wdata_q;
         CYC_MODIFY:  target = held_q ? wdata_q
                                      : (rdata_q & ~mask_q) | (wdata_q & mask_q);
         default:     target = rdata_q;
      endcase
   end

   assign rd_drv     = (st == ST_READ);
   assign wr_drv     = (st == ST_WRITE);
   assign sense_strb = rd_drv && tmr_last;
   assign busy       = (st != ST_IDLE);
   assign ack        = ack_q;
   assign done       = done_q;
   assign rdata      = rdata_q;
   assign inhibit    = (st == ST_SETUP || st == ST_WRITE) ? ~target : '0;
   assign drive_on   = rd_drv || wr_drv;

   coinc_line_decode #(.IDX_W(X_W)) u_xdec (
      .idx   (addr_q[ADDR_W-1:Y_W]),
      .en    (drive_on),
      .lines (x_sel)
   );

   coinc_line_decode #(.IDX_W(Y_W)) u_ydec (
      .idx   (addr_q[Y_W-1:0]),
      .en    (drive_on),
      .lines (y_sel)
   );
endmodule

// File: rtl/coinc_core_seq_chk.sv
module coinc_core_seq_chk #(
   parameter int DATA_W  = 16,
   parameter int X_LINES = 64,
   parameter int Y_LINES = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack,
   input logic               busy,
   input logic               done,
   input logic               sense_strb,
   input logic               rd_drv,
   input logic               wr_drv,
   input logic [X_LINES-1:0] x_sel,
   input logic [Y_LINES-1:0] y_sel,
   input logic [DATA_W-1:0]  inhibit
);
   logic restore_pend;

   always_ff @(posedge clk) begin
      if (!rst_n)
         restore_pend <= 1'b0;
      else if (sense_strb)
         restore_pend <= 1'b1;
      else if (wr_drv)
         restore_pend <= 1'b0;
   end

   AST_XY_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_drv || wr_drv) |-> ($countones(x_sel) == 1 && $countones(y_sel) == 1)); // R1
   AST_XY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_drv || wr_drv) |-> (x_sel == '0 && y_sel == '0)); // R1
   AST_ACK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (busy && $past(!busy))); // R2
   AST_STROBE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      sense_strb |=> !rd_drv); // R3
   AST_STROBE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      sense_strb |-> rd_drv); // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4
   AST_RESTORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !restore_pend); // R5
   AST_DRIVES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_drv && wr_drv)); // R5
   AST_INH_NOT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_drv |-> (inhibit == '0)); // R6
   AST_INH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drv |-> $stable(inhibit)); // R6
endmodule

bind coinc_core_seq coinc_core_seq_chk #(
   .DATA_W  (DATA_W),
   .X_LINES (X_LINES),
   .Y_LINES (Y_LINES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack        (ack),
   .busy       (busy),
   .done       (done),
   .sense_strb (sense_strb),
   .rd_drv     (rd_drv),
   .wr_drv     (wr_drv),
   .x_sel      (x_sel),
   .y_sel      (y_sel),
   .inhibit    (inhibit)
);

// File: tb/tb_coinc_core_seq.sv
module tb_coinc_core_seq;
   localparam int G = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [11:0] req_addr = '0;
   logic [15:0] req_wdata = '0, req_mask = '0;
   logic [7:0]  rd_width = '0, wr_width = '0;
   logic        hold_en = 1'b0, wdata_vld = 1'b0;
   logic        ack, busy, done, sense_strb, rd_drv, wr_drv;
   logic [15:0] rdata, sense, inhibit;
   logic [63:0] x_sel, y_sel;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   coinc_core_seq #(.GAP_CYC(G)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .rd_width(rd_width), .wr_width(wr_width), .hold_en(hold_en),
      .wdata_vld(wdata_vld), .ack(ack), .busy(busy), .done(done),
      .rdata(rdata), .sense(sense), .sense_strb(sense_strb),
      .rd_drv(rd_drv), .wr_drv(wr_drv), .x_sel(x_sel), .y_sel(y_sel),
      .inhibit(inhibit)
   );

   // behavioural plane: read clears the word, write sets non-inhibited bits
   logic [15:0] plane [int];
   logic [15:0] shadow [int];
   logic [15:0] rd_old = '0;
   bit          in_read = 1'b0;

   function automatic logic [15:0] pget(int a);
      return plane.exists(a) ? plane[a] : 16'h0000;
   endfunction

   function automatic int sel_addr();
      int xi = 0;
      int yi = 0;
      for (int i = 0; i < 64; i++) begin
         if (x_sel[i]) xi = i;
         if (y_sel[i]) yi = i;
      end
      return xi * 64 + yi;
   endfunction

   assign sense = rd_drv ? rd_old : 16'h0000;

   always @(negedge clk) begin
      if (rd_drv && !in_read) begin
         rd_old = pget(sel_addr());
         plane[sel_addr()] = 16'h0000;
         in_read = 1'b1;
      end
      if (!rd_drv) in_read = 1'b0;
      if (wr_drv) plane[sel_addr()] = pget(sel_addr()) | ~inhibit;
   end

   function automatic logic [149:0] pins();
      return {busy, ack, done, rd_drv, wr_drv, sense_strb, inhibit, x_sel, y_sel};
   endfunction

   task automatic chk_pins(string tag, logic [149:0] exp);
      total++;
      if (pins() !== exp) begin
         bad++;
         $display("FAIL %s t=%0t pins actual=%h expected=%h", tag, $time, pins(), exp);
      end
   endtask

   task automatic chk_word(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   function automatic logic [149:0] mk(bit b, bit a, bit d, bit r, bit w, bit s,
                                       logic [15:0] inh, bit sel, logic [11:0] ad);
      logic [63:0] xs, ys;
      xs = sel ? (64'd1 << ad[11:6]) : 64'd0;
      ys = sel ? (64'd1 << ad[5:0]) : 64'd0;
      return {b, a, d, r, w, s, inh, xs, ys};
   endfunction

   // one full access, compared against expectations on every clock
   task automatic access(logic [1:0] kind, logic [11:0] addr, logic [15:0] wd,
                         logic [15:0] mask, int rw, int ww, bit hold,
                         int hwait, logic [15:0] hdata, bit stray, string ktag);
      logic [15:0] old, tgt;
      int re, we;
      bit stall;
      old = shadow.exists(int'(addr)) ? shadow[int'(addr)] : 16'h0000;
      stall = hold && (kind == 2'd2);
      case (kind)
         2'd1:    tgt = wd;
         2'd2:    tgt = stall ? hdata : ((old & ~mask) | (wd & mask));
         default: tgt = old;
      endcase
      re = (rw == 0) ? 1 : rw;
      we = (ww == 0) ? 1 : ww;
      chk_pins("R2 idle before request", mk(0,0,0,0,0,0,16'h0,0,addr));
      req = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
      req_mask = mask; rd_width = 8'(rw); wr_width = 8'(ww); hold_en = hold;
      @(negedge clk);
      req = 1'b0;
      if (stray) wdata_vld = 1'b1;
      for (int k = 1; k <= re; k++) begin
         if (k > 1) @(negedge clk);
         chk_pins("R3 read drive", mk(1, k == 1, 0, 1, 0, k == re, 16'h0, 1, addr));
         wdata_vld = 1'b0;
      end
      for (int g = 1; g <= G; g++) begin
         @(negedge clk);
         chk_pins("R11 read gap", mk(1, 0, g == 1, 0, 0, 0, 16'h0, 0, addr));
         if (g == 1) chk_word("R4 rdata", rdata, old);
         req = stray && (g == 1);
         wdata_vld = stray && (g == 1);
      end
      req = 1'b0; wdata_vld = 1'b0;
      if (stall) begin
         for (int h = 0; h <= hwait; h++) begin
            @(negedge clk);
            chk_pins("R10 stall", mk(1, 0, 0, 0, 0, 0, 16'h0, 0, addr));
            if (h == hwait) begin
               wdata_vld = 1'b1;
               req_wdata = hdata;
            end
         end
      end
      @(negedge clk);
      wdata_vld = 1'b0;
      req_wdata = wd;
      chk_pins("R6 inhibit setup", mk(1, 0, 0, 0, 0, 0, ~tgt, 0, addr));
      for (int w = 1; w <= we; w++) begin
         @(negedge clk);
         chk_pins("R6 write drive", mk(1, 0, 0, 0, 1, 0, ~tgt, 1, addr));
      end
      for (int g = 1; g <= G; g++) begin
         @(negedge clk);
         chk_pins("R11 write gap", mk(1, 0, 0, 0, 0, 0, 16'h0, 0, addr));
      end
      @(negedge clk);
      chk_pins("R5 busy released after restore", mk(0, 0, 0, 0, 0, 0, 16'h0, 0, addr));
      chk_word("R4 rdata held", rdata, old);
      chk_word(ktag, pget(int'(addr)), tgt);
      shadow[int'(addr)] = tgt;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_pins("R12 reset state", mk(0,0,0,0,0,0,16'h0,0,12'h0));
      chk_word("R12 reset rdata", rdata, 16'h0000);
      access(2'd0, 12'h000, 16'h0, 16'h0, 2, 2, 0, 0, 16'h0, 0, "R7 restore of blank word");
      access(2'd1, 12'hABC, 16'hA5C3, 16'h0, 1, 3, 0, 0, 16'h0, 0, "R8 clear-write stores data");
      access(2'd0, 12'hABC, 16'h0, 16'h0, 0, 0, 0, 0, 16'h0, 0, "R7 restore with zero widths");
      access(2'd2, 12'hABC, 16'h0FF0, 16'h00FF, 3, 2, 0, 0, 16'h0, 0, "R9 modify under mask");
      access(2'd1, 12'hFFF, 16'hFFFF, 16'h0, 2, 1, 0, 0, 16'h0, 1, "R2 stray req and R10 stray valid ignored");
      access(2'd2, 12'hFFF, 16'h0000, 16'hFFFF, 2, 2, 1, 3, 16'h1234, 0, "R10 stalled modify data");
      access(2'd0, 12'h041, 16'h0, 16'h0, 1, 1, 1, 0, 16'h0, 0, "R10 stall only for modify");
      access(2'd1, 12'h041, 16'h8001, 16'h0, 4, 1, 0, 0, 16'h0, 0, "R8 clear-write edge bits");
      access(2'd3, 12'hABC, 16'hFFFF, 16'hFFFF, 1, 2, 0, 0, 16'h0, 0, "R7 kind 3 acts as restore");
      access(2'd2, 12'h041, 16'h7FFE, 16'h0000, 2, 2, 0, 0, 16'h0, 0, "R9 zero mask keeps word");
      access(2'd2, 12'h041, 16'h3C3C, 16'hFFFF, 1, 1, 0, 0, 16'h0, 0, "R9 full mask takes host");
      access(2'd0, 12'h041, 16'h0, 16'h0, 1, 1, 0, 0, 16'h0, 0, "R7 restore after modify");
      access(2'd0, 12'h000, 16'h0, 16'h0, 1, 1, 0, 0, 16'h0, 0, "R1 corner address restore");
      summary();
   end
endmodule